// File: doc/BRIEF.md
# Flag-Gated Arithmetic Logic Unit

A 16-bit two's complement datapath unit for a small processor. A 4-bit opcode selects add, subtract, AND, OR, bitwise NOT, logical left shift or arithmetic right shift. Operands `a_i` and `b_i` are combined with no clock, and the 16-bit result appears on `res_o` in the same cycle. Any opcode with no operation of its own passes `b_i` through, so data loaded from memory can reach the destination unchanged.

Two condition flags, zero and negative, are held in registers. They load on a rising clock edge only when `valid_i` is high and the instruction's set-flags bit `setf_i` is 1. Both flags clear on reset. The shift distance comes from the low four bits of `b_i`, so a shift moves the value by 0 to 15 places.

Top module: `alu_flagged`

## Requirements
- R1: Opcodes 0 and 1 give `res_o = a_i + b_i` modulo 2^16, and opcodes 2 and 3 give `res_o = a_i - b_i` modulo 2^16. The result appears with no clock delay.
- R2: Opcode 4 gives `a_i & b_i`, opcode 7 gives `a_i | b_i`, and opcode 8 gives `~b_i`.
- R3: Opcode 5 shifts `a_i` left by `b_i[3:0]` places and fills with zeros.
- R4: Opcode 6 shifts `a_i` right by `b_i[3:0]` places and copies bit 15 into the vacated positions. Bits 15 down to 4 of `b_i` have no effect on either shift.
- R5: Opcodes 9 through 15 give `res_o = b_i`.
- R6: When `valid_i` and `setf_i` are both 1 at a rising clock edge, `zero_o` becomes 1 exactly when `res_o` is 0. The flag takes its new value at that edge.
- R7: When `valid_i` and `setf_i` are both 1 at a rising clock edge, `neg_o` takes the value of `res_o` bit 15.
- R8: When `setf_i` is 0 or `valid_i` is 0 at a clock edge, both flags keep their previous values.
- R9: While `rst_ni` is low, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe; qualifies the flag update |
| setf_i | input | 1 | Set-flags bit of the instruction |
| op_i | input | 4 | Opcode |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand; bits 3:0 give the shift distance |
| res_o | output | 16 | Result |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |

## Verification
`res_o` is a function of the current inputs alone. The bench applies operands and opcode away from the clock edge, waits one time step, and compares the result against its own model in the same cycle. The flags change one clock edge after a qualified strobe. Flag checks therefore drive the strobe, let one rising edge pass, and sample a quarter period later. Held-flag cases change the opcode and operands so that updating the flags would give different values, then confirm that the flags did not move.

// File: rtl/alu_flagged_pkg.sv
package alu_flagged_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD0 = 4'd0, OP_ADD1 = 4'd1, OP_SUB0 = 4'd2, OP_SUB1 = 4'd3,
    OP_AND  = 4'd4, OP_SHL  = 4'd5, OP_SRA  = 4'd6, OP_OR   = 4'd7,
    OP_NOT  = 4'd8
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic neg;
  } flags_t;
endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W = 16,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          right_i,
  output logic [W-1:0]  out_o
);
  // log-depth barrel; right shifts replicate the sign bit
  logic [W-1:0] stage [SW+1];
  assign stage[0] = val_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    always_comb begin
      if (!amt_i[s])
        stage[s+1] = stage[s];
      else if (right_i)
        stage[s+1] = {{D{val_i[W-1]}}, stage[s][W-1:D]};
      else
        stage[s+1] = {stage[s][W-1-D:0], {D{1'b0}}};
    end
  end

  assign out_o = stage[SW];

  always_comb begin
    if (amt_i == '0) assert_zero_shift_R4: assert (out_o == val_i);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flagged_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] res_i,
  output flags_t       flags_o
);
  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= '{zero: (res_i == '0), neg: res_i[W-1]};
  end

  assign flags_o = q;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q));
  assert_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q.zero == ($past(res_i) == '0)));
  assert_neg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q.neg == $past(res_i[W-1])));
  assert_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> !(q.zero && q.neg));
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_flagged_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          setf_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          zero_o,
  output logic          neg_o
);
  localparam int unsigned SW = $clog2(DW);

  logic [DW-1:0] sum, dif, shl, sra;
  flags_t        flags;

  assign sum = a_i + b_i;
  assign dif = a_i - b_i;

  alu_shifter #(.W(DW)) u_shl (.val_i(a_i), .amt_i(b_i[SW-1:0]), .right_i(1'b0), .out_o(shl));
  alu_shifter #(.W(DW)) u_sra (.val_i(a_i), .amt_i(b_i[SW-1:0]), .right_i(1'b1), .out_o(sra));

  always_comb begin
    unique case (op_i)
      OP_ADD0, OP_ADD1: res_o = sum;
      OP_SUB0, OP_SUB1: res_o = dif;
      OP_AND:           res_o = a_i & b_i;
      OP_SHL:           res_o = shl;
      OP_SRA:           res_o = sra;
      OP_OR:            res_o = a_i | b_i;
      OP_NOT:           res_o = ~b_i;
      default:          res_o = b_i;
    endcase
  end

  alu_flag_reg #(.W(DW)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i && setf_i),
    .res_i(res_o), .flags_o(flags)
  );

  assign zero_o = flags.zero;
  assign neg_o  = flags.neg;

  always_comb begin
    if (op_i > 4'd8) assert_pass_R5: assert (res_o == b_i);
  end
  assert_rst_R9: assert property (@(posedge clk_i) !rst_ni |-> (!zero_o && !neg_o));
endmodule

// File: tb/alu_flagged_test.sv
`timescale 1ns/1ps
module alu_flagged_test;
  logic clk = 0, rst_n = 0, valid = 0, setf = 0;
  logic [3:0] op = 0;
  logic [15:0] a = 0, b = 0, res;
  logic zf, nf;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  alu_flagged uut (.clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .setf_i(setf),
    .op_i(op), .a_i(a), .b_i(b), .res_o(res), .zero_o(zf), .neg_o(nf));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [15:0] x, logic [15:0] y);
    @(negedge clk); op = o; a = x; b = y; #0.5;
  endtask

  task automatic t_reset();
    chk("R9 zero", {15'd0, zf}, 16'd0);
    chk("R9 neg", {15'd0, nf}, 16'd0);
  endtask

  task automatic t_arith();
    apply(0, 16'h1234, 16'h0FF1); chk("R1 add0", res, 16'h2225);
    apply(1, 16'hFFFF, 16'h0002); chk("R1 add1 wrap", res, 16'h0001);
    apply(2, 16'h0005, 16'h0007); chk("R1 sub0", res, 16'hFFFE);
    apply(3, 16'h8000, 16'h0001); chk("R1 sub1", res, 16'h7FFF);
  endtask

  task automatic t_logic();
    apply(4, 16'hF0F0, 16'h3C3C); chk("R2 and", res, 16'h3030);
    apply(7, 16'hF0F0, 16'h0F01); chk("R2 or", res, 16'hFFF1);
    apply(8, 16'h1234, 16'h00FF); chk("R2 not", res, 16'hFF00);
  endtask

  task automatic t_shift();
    for (int s = 0; s < 16; s++) begin
      apply(5, 16'hA5C3, 16'hFFF0 | 16'(s));
      chk("R3 shl", res, 16'hA5C3 << s);
      apply(6, 16'hA5C3, 16'h1230 | 16'(s));
      chk("R4 sra", res, 16'($signed(16'hA5C3) >>> s));
    end
    apply(6, 16'h4001, 16'h000F); chk("R4 sra pos", res, 16'h0000);
  endtask

  task automatic t_pass();
    for (int o = 9; o < 16; o++) begin
      apply(4'(o), 16'h1111, 16'hBEEF); chk("R5 pass", res, 16'hBEEF);
    end
  endtask

  task automatic t_flags();
    apply(2, 16'h0003, 16'h0003); valid = 1; setf = 1;
    @(posedge clk); #1; valid = 0;
    chk("R6 zero set", {15'd0, zf}, 16'd1);
    chk("R7 neg clr", {15'd0, nf}, 16'd0);
    apply(2, 16'h0001, 16'h0004); valid = 1;
    @(posedge clk); #1; valid = 0;
    chk("R6 zero clr", {15'd0, zf}, 16'd0);
    chk("R7 neg set", {15'd0, nf}, 16'd1);
    // S=0 with valid: hold
    apply(0, 16'h0000, 16'h0000); setf = 0; valid = 1;
    @(posedge clk); #1; valid = 0;
    chk("R8 hold s0 zero", {15'd0, zf}, 16'd0);
    chk("R8 hold s0 neg", {15'd0, nf}, 16'd1);
    // S=1 without valid: hold
    setf = 1;
    @(posedge clk); #1;
    chk("R8 hold nv zero", {15'd0, zf}, 16'd0);
    chk("R8 hold nv neg", {15'd0, nf}, 16'd1);
    apply(9, 16'hFFFF, 16'h7000); valid = 1;
    @(posedge clk); #1; valid = 0; setf = 0;
    chk("R7 pass flags neg", {15'd0, nf}, 16'd0);
    chk("R6 pass flags zero", {15'd0, zf}, 16'd0);
  endtask

  task automatic t_reset_mid();
    apply(0, 16'h0000, 16'h0000); valid = 1; setf = 1;
    @(posedge clk); #1; valid = 0; setf = 0;
    chk("R6 pre-reset", {15'd0, zf}, 16'd1);
    rst_n = 0; #1;
    chk("R9 async clear", {15'd0, zf}, 16'd0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1; t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_arith(); t_logic(); t_shift(); t_pass(); t_flags(); t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule